// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Ring Protection

This block translates a 32-bit virtual address through a small set-associative table of page entries. Every way is searched in the same cycle. An entry matches when its stored virtual page number equals the page number of the address and its address-space tag is nonzero and appears in a four-byte ring register. That register assigns one tag to each protection ring from 0 to 3. For a single match, the block returns the way, the entry index, the ring, the physical address and the read/write/execute rights for the request. In every other case it returns a fault cause.

A lookup is purely combinational and reads registered storage. Entries are written through one write port. The caller either names the target way or lets an internal round-robin counter pick it, which is how refill data from an external page-table walker is loaded. The ring register is loaded through its own write strobe. The access type of each request (load, store or fetch) selects the instruction or data flavour of each fault cause and masks the rights.

Top module: `xtlb_top`

## Requirements
- R1: After reset every entry's tag is 0, so every lookup misses. The ring register holds 0x04030201, meaning tag 1 maps to ring 0, tag 2 to ring 1, tag 3 to ring 2 and tag 4 to ring 3.
- R2: Byte i of the ring register (bits 8i+7:8i) gives the tag of ring i. When a tag appears in more than one byte, the lowest byte wins. The register changes only in the cycle after `ring_we_i` is high.
- R3: A way hits when the stored page number equals `lk_vaddr_i[31:12]` at index `lk_vaddr_i[13:12]`, the stored tag is nonzero and the tag is in the ring register. With no hit, `cause_o` is 16 for a fetch and 24 for a load or store. A clean single hit gives `cause_o` 0.
- R4: Two or more hitting ways give `cause_o` 17 for a fetch and 25 for a load or store.
- R5: On a single hit whose ring is numerically below `lk_priv_i`, `cause_o` is 18 for a fetch and 26 otherwise. Miss and multi-hit take precedence over this cause, and this cause takes precedence over R8.
- R6: `rights_o` bit 0 is read, bit 1 is write and bit 2 is execute. Attributes below 12 grant read, with attribute bit 0 adding execute and attribute bit 1 adding write. Attribute 13 grants read and write. All other attributes grant nothing.
- R7: `cache_o` is 0 for bypass, 1 for write-back, 2 for write-through and 3 for isolate. For attributes below 12, bits 3:2 equal to 0, 1 or 2 select bypass, write-back or write-through. Attribute 13 is isolate. All others report 0.
- R8: `lk_acc_i` is 0 for a load, 1 for a store and 2 for a fetch. Load and store requests lose execute rights. Fetch requests lose read and write rights. A denied access gives `cause_o` 20 for a fetch, 28 for a load and 29 for a store.
- R9: On a single hit, `hit_way_o` and `hit_idx_o` name the entry and `hit_ring_o` its ring. `paddr_o` is the entry's 20-bit physical page followed by `lk_vaddr_i[11:0]`. On a miss or multi-hit, rights and cache are 0.
- R10: A write with `wr_auto_i` high goes to the way given by a counter that is incremented first and then used modulo 4. The first automatic write after reset lands in way 1, the next ones in ways 2, 3, 0 and so on. A write with `wr_auto_i` low goes to `wr_way_i` and leaves the counter unchanged.
- R11: A written entry becomes visible to lookups in the cycle after the write. A lookup in the same cycle as the write still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_we_i | input | 1 | Load the ring register |
| ring_wdata_i | input | 32 | New ring register value |
| lk_vaddr_i | input | 32 | Lookup virtual address |
| lk_acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| lk_priv_i | input | 2 | Requesting privilege index |
| wr_en_i | input | 1 | Entry write strobe |
| wr_auto_i | input | 1 | Use round-robin way selection |
| wr_way_i | input | 2 | Explicit target way |
| wr_vaddr_i | input | 32 | Virtual address giving page number and index |
| wr_ppn_i | input | 20 | Physical page number |
| wr_asid_i | input | 8 | Address-space tag |
| wr_attr_i | input | 4 | Attribute code |
| cause_o | output | 6 | Fault cause, 0 when the translation is clean |
| hit_way_o | output | 2 | Way of the single hit |
| hit_idx_o | output | 2 | Entry index of the single hit |
| hit_ring_o | output | 2 | Ring of the single hit |
| paddr_o | output | 32 | Physical address |
| rights_o | output | 3 | Granted rights {exec, write, read} |
| cache_o | output | 2 | Cache mode |

## Verification
All lookup results are combinational, so they are due in the same cycle the request is presented. The bench drives each request on the falling edge and samples 2 ns later, before the next rising edge. Entry and ring writes take effect one rising edge after they are presented. The reference model applies a cycle's writes only after that cycle's comparison, which reproduces the one-cycle delay of R11 without reading any RTL state. The automatic way pointer advances on the same edge as the write it serves, so a lookup one cycle after an automatic refill shows the way that was chosen.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [5:0] C_NONE    = 6'd0;
  localparam logic [5:0] C_IMISS   = 6'd16;
  localparam logic [5:0] C_IMULTI  = 6'd17;
  localparam logic [5:0] C_IPRIV   = 6'd18;
  localparam logic [5:0] C_IPROHIB = 6'd20;
  localparam logic [5:0] C_DMISS   = 6'd24;
  localparam logic [5:0] C_DMULTI  = 6'd25;
  localparam logic [5:0] C_DPRIV   = 6'd26;
  localparam logic [5:0] C_LPROHIB = 6'd28;
  localparam logic [5:0] C_SPROHIB = 6'd29;

  localparam logic [1:0] CM_BYPASS  = 2'd0;
  localparam logic [1:0] CM_WBACK   = 2'd1;
  localparam logic [1:0] CM_WTHRU   = 2'd2;
  localparam logic [1:0] CM_ISOLATE = 2'd3;
endpackage

// File: rtl/xtlb_ring_map.sv
module xtlb_ring_map #(
  parameter int RINGS  = 4,
  parameter int ASID_W = 8
) (
  input  logic [ASID_W-1:0]       asid_i,
  input  logic [RINGS*ASID_W-1:0] ring_reg_i,
  output logic                    found_o,
  output logic [$clog2(RINGS)-1:0] ring_o
);
  localparam int RING_W = $clog2(RINGS);

  // lowest matching byte wins: scan from the top down
  always_comb begin
    found_o = 1'b0;
    ring_o  = '0;
    for (int r = RINGS - 1; r >= 0; r--) begin
      if (ring_reg_i[r*ASID_W +: ASID_W] == asid_i) begin
        found_o = 1'b1;
        ring_o  = RING_W'(r);
      end
    end
  end
endmodule

// File: rtl/xtlb_way.sv
module xtlb_way #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int ATTR_W  = 4,
  parameter int RINGS   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [VPN_W-1:0]         wr_vpn_i,
  input  logic [PPN_W-1:0]         wr_ppn_i,
  input  logic [ASID_W-1:0]        wr_asid_i,
  input  logic [ATTR_W-1:0]        wr_attr_i,
  input  logic [VPN_W-1:0]         rd_vpn_i,
  input  logic [RINGS*ASID_W-1:0]  ring_reg_i,
  output logic                     hit_o,
  output logic [$clog2(RINGS)-1:0] ring_o,
  output logic [PPN_W-1:0]         ppn_o,
  output logic [ATTR_W-1:0]        attr_o
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int RING_W = $clog2(RINGS);

  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][ATTR_W-1:0] attr_q;

  logic [IDX_W-1:0] wr_idx, rd_idx;
  assign wr_idx = wr_vpn_i[IDX_W-1:0];
  assign rd_idx = rd_vpn_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpn_q  <= '0;
      ppn_q  <= '0;
      asid_q <= '0;
      attr_q <= '0;
    end else if (we_i) begin
      vpn_q[wr_idx]  <= wr_vpn_i;
      ppn_q[wr_idx]  <= wr_ppn_i;
      asid_q[wr_idx] <= wr_asid_i;
      attr_q[wr_idx] <= wr_attr_i;
    end
  end

  logic              ring_found;
  logic [RING_W-1:0] ring_num;

  xtlb_ring_map #(.RINGS(RINGS), .ASID_W(ASID_W)) u_ring_map (
    .asid_i    (asid_q[rd_idx]),
    .ring_reg_i(ring_reg_i),
    .found_o   (ring_found),
    .ring_o    (ring_num)
  );

  assign hit_o  = (vpn_q[rd_idx] == rd_vpn_i) && (asid_q[rd_idx] != '0) && ring_found;
  assign ring_o = ring_num;
  assign ppn_o  = ppn_q[rd_idx];
  assign attr_o = attr_q[rd_idx];

  // R11
  entry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(asid_q) && $stable(vpn_q)));
endmodule

// File: rtl/xtlb_attr_dec.sv
module xtlb_attr_dec
  import xtlb_pkg::*;
(
  input  logic [3:0] attr_i,
  input  logic [1:0] acc_i,
  output logic [2:0] rights_o,
  output logic [1:0] cache_o,
  output logic       granted_o
);
  logic [2:0] raw;

  always_comb begin
    raw     = 3'b000;
    cache_o = CM_BYPASS;
    if (attr_i < 4'd12) begin
      raw = {attr_i[0], attr_i[1], 1'b1};
      unique case (attr_i[3:2])
        2'd1:    cache_o = CM_WBACK;
        2'd2:    cache_o = CM_WTHRU;
        default: cache_o = CM_BYPASS;
      endcase
    end else if (attr_i == 4'd13) begin
      raw     = 3'b011;
      cache_o = CM_ISOLATE;
    end
  end

  // instruction side keeps only execute, data side drops it
  assign rights_o = (acc_i == ACC_FETCH) ? (raw & 3'b100) : (raw & 3'b011);

  always_comb begin
    unique case (acc_i)
      ACC_STORE: granted_o = rights_o[1];
      ACC_FETCH: granted_o = rights_o[2];
      default:   granted_o = rights_o[0];
    endcase
  end
endmodule

// File: rtl/xtlb_rr.sv
module xtlb_rr #(
  parameter int NUM_WAYS = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        adv_i,
  output logic [$clog2(NUM_WAYS)-1:0] next_o
);
  localparam int WAY_W = $clog2(NUM_WAYS);

  logic [WAY_W-1:0] cnt_q;

  // pre-increment: the way used is one past the stored count
  assign next_o = cnt_q + WAY_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= next_o;
  end

  // R10
  rr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (next_o == $past(next_o) + WAY_W'(1)));

  // R10
  rr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(next_o));
endmodule

// File: rtl/xtlb_top.sv
module xtlb_top
  import xtlb_pkg::*;
#(
  parameter int          VA_W        = 32,
  parameter int          PA_W        = 32,
  parameter int          PAGE_BITS   = 12,
  parameter int          NUM_WAYS    = 4,
  parameter int          WAY_ENTRIES = 4,
  parameter int          ASID_W      = 8,
  parameter int          RINGS       = 4,
  parameter logic [31:0] RING_RST    = 32'h0403_0201
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              ring_we_i,
  input  logic [RINGS*ASID_W-1:0]           ring_wdata_i,
  input  logic [VA_W-1:0]                   lk_vaddr_i,
  input  logic [1:0]                        lk_acc_i,
  input  logic [$clog2(RINGS)-1:0]          lk_priv_i,
  input  logic                              wr_en_i,
  input  logic                              wr_auto_i,
  input  logic [$clog2(NUM_WAYS)-1:0]       wr_way_i,
  input  logic [VA_W-1:0]                   wr_vaddr_i,
  input  logic [PA_W-PAGE_BITS-1:0]         wr_ppn_i,
  input  logic [ASID_W-1:0]                 wr_asid_i,
  input  logic [3:0]                        wr_attr_i,
  output logic [5:0]                        cause_o,
  output logic [$clog2(NUM_WAYS)-1:0]       hit_way_o,
  output logic [$clog2(WAY_ENTRIES)-1:0]    hit_idx_o,
  output logic [$clog2(RINGS)-1:0]          hit_ring_o,
  output logic [PA_W-1:0]                   paddr_o,
  output logic [2:0]                        rights_o,
  output logic [1:0]                        cache_o
);
  localparam int WAY_W  = $clog2(NUM_WAYS);
  localparam int IDX_W  = $clog2(WAY_ENTRIES);
  localparam int RING_W = $clog2(RINGS);
  localparam int VPN_W  = VA_W - PAGE_BITS;
  localparam int PPN_W  = PA_W - PAGE_BITS;
  localparam int CNT_W  = $clog2(NUM_WAYS + 1);

  logic [RINGS*ASID_W-1:0] ring_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ring_q <= RING_RST[RINGS*ASID_W-1:0];
    else if (ring_we_i) ring_q <= ring_wdata_i;
  end

  logic [WAY_W-1:0] rr_way, tgt_way;

  xtlb_rr #(.NUM_WAYS(NUM_WAYS)) u_rr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (wr_en_i && wr_auto_i),
    .next_o(rr_way)
  );

  assign tgt_way = wr_auto_i ? rr_way : wr_way_i;

  logic [VPN_W-1:0] lk_vpn;
  assign lk_vpn = lk_vaddr_i[VA_W-1:PAGE_BITS];

  logic [NUM_WAYS-1:0]             hit_vec;
  logic [NUM_WAYS-1:0][RING_W-1:0] way_ring;
  logic [NUM_WAYS-1:0][PPN_W-1:0]  way_ppn;
  logic [NUM_WAYS-1:0][3:0]        way_attr;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    xtlb_way #(
      .ENTRIES(WAY_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
      .ASID_W (ASID_W),      .ATTR_W(4),    .RINGS(RINGS)
    ) u_way (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (wr_en_i && (tgt_way == WAY_W'(w))),
      .wr_vpn_i  (wr_vaddr_i[VA_W-1:PAGE_BITS]),
      .wr_ppn_i  (wr_ppn_i),
      .wr_asid_i (wr_asid_i),
      .wr_attr_i (wr_attr_i),
      .rd_vpn_i  (lk_vpn),
      .ring_reg_i(ring_q),
      .hit_o     (hit_vec[w]),
      .ring_o    (way_ring[w]),
      .ppn_o     (way_ppn[w]),
      .attr_o    (way_attr[w])
    );
  end

  logic [CNT_W-1:0]  n_hits;
  logic [WAY_W-1:0]  sel_way;
  logic [RING_W-1:0] sel_ring;
  logic [PPN_W-1:0]  sel_ppn;
  logic [3:0]        sel_attr;

  always_comb begin
    n_hits   = '0;
    sel_way  = '0;
    sel_ring = '0;
    sel_ppn  = '0;
    sel_attr = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hit_vec[w]) begin
        n_hits   = n_hits + CNT_W'(1);
        sel_way  = WAY_W'(w);
        sel_ring = way_ring[w];
        sel_ppn  = way_ppn[w];
        sel_attr = way_attr[w];
      end
    end
  end

  logic [2:0] dec_rights;
  logic [1:0] dec_cache;
  logic       granted;

  xtlb_attr_dec u_attr (
    .attr_i   (sel_attr),
    .acc_i    (lk_acc_i),
    .rights_o (dec_rights),
    .cache_o  (dec_cache),
    .granted_o(granted)
  );

  logic single, is_fetch, is_store;
  assign single   = (n_hits == CNT_W'(1));
  assign is_fetch = (lk_acc_i == ACC_FETCH);
  assign is_store = (lk_acc_i == ACC_STORE);

  // priority: miss / multi, then privilege, then permission
  always_comb begin
    if (n_hits == '0)          cause_o = is_fetch ? C_IMISS  : C_DMISS;
    else if (!single)          cause_o = is_fetch ? C_IMULTI : C_DMULTI;
    else if (sel_ring < lk_priv_i) cause_o = is_fetch ? C_IPRIV : C_DPRIV;
    else if (!granted)         cause_o = is_fetch ? C_IPROHIB :
                                         (is_store ? C_SPROHIB : C_LPROHIB);
    else                       cause_o = C_NONE;
  end

  assign hit_way_o  = sel_way;
  assign hit_idx_o  = lk_vpn[IDX_W-1:0];
  assign hit_ring_o = sel_ring;
  assign paddr_o    = {sel_ppn, lk_vaddr_i[PAGE_BITS-1:0]};
  assign rights_o   = single ? dec_rights : 3'b000;
  assign cache_o    = single ? dec_cache  : CM_BYPASS;

  // R4
  multi_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(hit_vec) > 1) |-> (cause_o == C_IMULTI || cause_o == C_DMULTI));

  // R3
  clean_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o == C_NONE) |-> ($countones(hit_vec) == 1));

  // R5
  priv_ring_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o == C_IPRIV || cause_o == C_DPRIV) |-> (hit_ring_o < lk_priv_i));

  // R8
  fetch_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o == C_NONE && is_fetch) |-> (rights_o == 3'b100));

  // R2
  ring_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ring_we_i |=> $stable(ring_q));
endmodule

// File: tb/xtlb_top_tb_top.sv
module xtlb_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ring_we = 1'b0;
  logic [31:0] ring_wdata = '0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_acc = 2'd0;
  logic [1:0]  lk_priv = 2'd0;
  logic        wr_en = 1'b0, wr_auto = 1'b0;
  logic [1:0]  wr_way = '0;
  logic [31:0] wr_vaddr = '0;
  logic [19:0] wr_ppn = '0;
  logic [7:0]  wr_asid = '0;
  logic [3:0]  wr_attr = '0;
  logic [5:0]  cause;
  logic [1:0]  hit_way, hit_idx, hit_ring;
  logic [31:0] paddr;
  logic [2:0]  rights;
  logic [1:0]  cache;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xtlb_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ring_we_i(ring_we), .ring_wdata_i(ring_wdata),
    .lk_vaddr_i(lk_vaddr), .lk_acc_i(lk_acc), .lk_priv_i(lk_priv),
    .wr_en_i(wr_en), .wr_auto_i(wr_auto), .wr_way_i(wr_way), .wr_vaddr_i(wr_vaddr),
    .wr_ppn_i(wr_ppn), .wr_asid_i(wr_asid), .wr_attr_i(wr_attr),
    .cause_o(cause), .hit_way_o(hit_way), .hit_idx_o(hit_idx), .hit_ring_o(hit_ring),
    .paddr_o(paddr), .rights_o(rights), .cache_o(cache)
  );

  // behavioural reference state
  int m_vpn [4][4];
  int m_ppn [4][4];
  int m_asid[4][4];
  int m_attr[4][4];
  int m_ring;
  int m_rr;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int w = 0; w < 4; w++)
      for (int e = 0; e < 4; e++) begin
        m_vpn[w][e] = 0; m_ppn[w][e] = 0; m_asid[w][e] = 0; m_attr[w][e] = 0;
      end
    m_ring = 32'h04030201;
    m_rr   = 0;
  endtask

  function automatic int ring_of(input int asid);
    for (int i = 0; i < 4; i++)
      if (((m_ring >> (8 * i)) & 255) == asid) return i;
    return -1;
  endfunction

  task automatic compare();
    int vpn, idx, nh, hw, hr, e_cause, e_rights, e_cache, a, r, wbit, x;
    string ctag;
    vpn = int'(lk_vaddr >> 12);
    idx = vpn % 4;
    nh = 0; hw = 0; hr = 0;
    for (int w = 0; w < 4; w++)
      if (m_vpn[w][idx] == vpn && m_asid[w][idx] != 0 && ring_of(m_asid[w][idx]) >= 0) begin
        nh++; hw = w; hr = ring_of(m_asid[w][idx]);
      end
    e_rights = 0; e_cache = 0;
    if (nh == 1) begin
      a = m_attr[hw][idx];
      if (a < 12) begin
        r = 1; x = a % 2; wbit = (a / 2) % 2;
        e_cache = (a / 4 == 1) ? 1 : (a / 4 == 2) ? 2 : 0;
      end else if (a == 13) begin
        r = 1; wbit = 1; x = 0; e_cache = 3;
      end else begin
        r = 0; wbit = 0; x = 0;
      end
      if (lk_acc == 2) e_rights = x * 4;
      else             e_rights = r + 2 * wbit;
    end
    if (nh == 0) begin
      e_cause = (lk_acc == 2) ? 16 : 24; ctag = "R3";
    end else if (nh > 1) begin
      e_cause = (lk_acc == 2) ? 17 : 25; ctag = "R4";
    end else if (hr < int'(lk_priv)) begin
      e_cause = (lk_acc == 2) ? 18 : 26; ctag = "R5";
    end else if ((lk_acc == 2 && e_rights != 4) ||
                 (lk_acc == 1 && (e_rights & 2) == 0) ||
                 (lk_acc == 0 && (e_rights & 1) == 0)) begin
      e_cause = (lk_acc == 2) ? 20 : (lk_acc == 1) ? 29 : 28; ctag = "R8";
    end else begin
      e_cause = 0; ctag = "R3";
    end
    chk(int'(cause), e_cause, {ctag, " cause"});
    chk(int'(rights), e_rights, "R6 rights");
    chk(int'(cache), e_cache, "R7 cache");
    if (nh == 1) begin
      chk(int'(hit_way), hw, "R9 way");
      chk(int'(hit_idx), idx, "R9 index");
      chk(int'(hit_ring), hr, "R2 ring");
      chk(int'(paddr), (m_ppn[hw][idx] << 12) | int'(lk_vaddr & 32'hfff), "R9 paddr");
    end
  endtask

  task automatic model_update();
    int w, vpn;
    if (wr_en) begin
      vpn = int'(wr_vaddr >> 12);
      if (wr_auto) begin
        m_rr = (m_rr + 1) % 4; w = m_rr;
      end else w = int'(wr_way);
      m_vpn[w][vpn % 4] = vpn; m_ppn[w][vpn % 4] = int'(wr_ppn);
      m_asid[w][vpn % 4] = int'(wr_asid); m_attr[w][vpn % 4] = int'(wr_attr);
    end
    if (ring_we) m_ring = int'(ring_wdata);
  endtask

  // entered at a falling edge with inputs already applied
  task automatic cyc();
    #2;
    compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
    wr_en = 1'b0; ring_we = 1'b0; wr_auto = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] acc, input logic [1:0] pr);
    lk_vaddr = va; lk_acc = acc; lk_priv = pr;
  endtask

  task automatic wr(input bit auto_sel, input logic [1:0] way, input logic [31:0] va,
                    input logic [19:0] ppn, input logic [7:0] asid, input logic [3:0] attr);
    wr_en = 1'b1; wr_auto = auto_sel; wr_way = way; wr_vaddr = va;
    wr_ppn = ppn; wr_asid = asid; wr_attr = attr;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: empty after reset
    look(32'h1234_5678, 2'd0, 2'd0);
    #2 chk(int'(cause), 24, "R1 reset miss");
    cyc();

    // R1 reset ring: tag 1 -> ring 0; R11 same-cycle write invisible
    wr(0, 2'd0, 32'h0000_1000, 20'h80001, 8'd1, 4'd7);
    look(32'h0000_1abc, 2'd0, 2'd0);
    #2 chk(int'(cause), 24, "R11 same-cycle write");
    cyc();
    look(32'h0000_1abc, 2'd0, 2'd0);
    #2 begin
      chk(int'(cause), 0, "R11 visible next cycle");
      chk(int'(hit_ring), 0, "R1 reset ring byte");
      chk(int'(paddr), 32'h8000_1abc, "R9 paddr");
      chk(int'(rights), 3'b011, "R8 data strips exec");
      chk(int'(cache), 1, "R7 write-back");
    end
    cyc();
    look(32'h0000_1abc, 2'd2, 2'd0);
    #2 chk(int'(rights), 3'b100, "R8 fetch strips rw");
    cyc();
    look(32'h0000_1abc, 2'd1, 2'd1);
    #2 chk(int'(cause), 26, "R5 privilege");
    cyc();

    // R4 duplicate page in way 2
    wr(0, 2'd2, 32'h0000_1000, 20'h00042, 8'd2, 4'd3);
    cyc();
    look(32'h0000_1abc, 2'd2, 2'd0);
    #2 chk(int'(cause), 17, "R4 multi fetch");
    cyc();

    // R2 drop tag 1 from the ring
    ring_we = 1'b1; ring_wdata = 32'h0403_0205;
    cyc();
    look(32'h0000_1abc, 2'd0, 2'd1);
    #2 begin
      chk(int'(cause), 0, "R2 tag removed");
      chk(int'(hit_way), 2, "R2 remaining way");
    end
    cyc();

    // R10 round robin
    for (int k = 0; k < 5; k++) begin
      wr(1, 2'd3, 32'h0010_0000 + 32'(k) * 32'h1000, 20'(k + 7), 8'd4, 4'd5);
      cyc();
      look(32'h0010_0000 + 32'(k) * 32'h1000, 2'd0, 2'd0);
      #2 chk(int'(hit_way), (k + 1) % 4, "R10 auto way");
      cyc();
    end

    // R6 R7 R8 attribute sweep
    for (int a = 0; a < 16; a++) begin
      wr(0, 2'd3, 32'h0020_3000, 20'h0abcd, 8'd3, 4'(a));
      cyc();
      for (int acc = 0; acc < 3; acc++) begin
        look(32'h0020_3010, 2'(acc), 2'd0);
        cyc();
      end
    end

    // R3 zero tag and absent tag
    wr(0, 2'd1, 32'h0030_0000, 20'h1, 8'd0, 4'd1);
    cyc();
    look(32'h0030_0004, 2'd0, 2'd0);
    #2 chk(int'(cause), 24, "R3 zero tag");
    cyc();
    wr(0, 2'd1, 32'h0030_0000, 20'h1, 8'd9, 4'd1);
    cyc();
    look(32'h0030_0004, 2'd2, 2'd0);
    #2 chk(int'(cause), 16, "R3 absent tag");
    cyc();

    // R2 duplicate ring bytes: lowest wins
    ring_we = 1'b1; ring_wdata = 32'h0909_0303;
    cyc();
    look(32'h0030_0004, 2'd2, 2'd0);
    #2 chk(int'(hit_ring), 2, "R2 lowest byte");
    cyc();

    // random traffic compared against the model each cycle
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 2) == 0)
        wr($urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)),
           32'($urandom_range(0, 15)) << 12, 20'($urandom), 8'($urandom_range(0, 5)),
           4'($urandom_range(0, 15)));
      if ($urandom_range(0, 40) == 0) begin
        ring_we = 1'b1;
        ring_wdata = {8'($urandom_range(0, 5)), 8'($urandom_range(0, 5)),
                      8'($urandom_range(0, 5)), 8'($urandom_range(0, 5))};
      end
      look((32'($urandom_range(0, 15)) << 12) | 32'($urandom_range(0, 4095)),
           2'($urandom_range(0, 2)), 2'($urandom_range(0, 3)));
      cyc();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule